// File: doc/BRIEF.md
# Parallel Self-Synchronising PRBS Error Checker

This block watches a received pseudo-random bit stream that arrives DATA_W bits per clock and flags every bit that breaks the selected pattern's recurrence. It keeps no seed and runs no local generator. Each accepted bit moves into a 31-stage history register. Each bit is then compared against the XOR of the two history stages that the chosen polynomial taps. A clean stream therefore yields zero flags once enough history has been collected. A corrupted stream resynchronises without help as soon as a polynomial length of good bits has gone past.

The received word can be complemented before the check, for patterns that are sent in inverted form. The bit order within a word is a build-time option. The block reports three things for every accepted word: a per-bit error mask, a saturating running total of flagged bits, and a lock flag with hysteresis. A link monitor uses these three outputs to judge link quality.

Top module: `prbs_par_checker`

## Requirements
- R1: `poly_sel_i` codes 0,1,2,3,4 select the recurrences x[n]=x[n-7]^x[n-6], x[n]=x[n-9]^x[n-5], x[n]=x[n-15]^x[n-14], x[n]=x[n-23]^x[n-18] and x[n]=x[n-31]^x[n-28]. Codes 5 to 7 act as code 4. The flag of received bit r[n] is r[n]^r[n-L]^r[n-T], where L is the length and T is the middle tap.
- R2: With LSB_FIRST=0, bit DATA_W-1 of a word is the earliest in the stream. With LSB_FIRST=1, bit 0 is the earliest. In both cases, `err_mask_o` bit i reports data bit i.
- R3: When `invert_i` is 1, every received bit is complemented before it is checked.
- R4: A cycle with `valid_i` low leaves the history unchanged. In the next cycle it shows `err_mask_o`=0 and `err_valid_o`=0. Unless `clear_i` is high, it keeps `err_count_o` and `locked_o` unchanged.
- R5: The first L accepted bits after reset never raise a flag.
- R6: The mask, the valid echo, the count and the lock flag for a word all appear in the cycle after the word is accepted.
- R7: A single flipped bit inside a clean locked stream raises exactly 3 flags in total.
- R8: Each accepted word adds the number of set bits of its mask to `err_count_o`. The count stops at 2^CNT_W-1.
- R9: `clear_i` zeroes `err_count_o` in the next cycle. It takes priority over the errors of a word accepted in the same cycle.
- R10: `locked_o` rises after LOCK_GOOD consecutive flag-free words and falls after UNLOCK_BAD consecutive flagged words. A word of the other kind restarts each run.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_sel_i | input | 3 | Pattern select code, held static between resets |
| invert_i | input | 1 | Complement received bits before checking |
| data_i | input | DATA_W | Received word |
| valid_i | input | 1 | Word on data_i is accepted this cycle |
| clear_i | input | 1 | Zero the error count |
| err_mask_o | output | DATA_W | Per-bit error flags of the last accepted word |
| err_valid_o | output | 1 | err_mask_o belongs to a word accepted last cycle |
| err_count_o | output | CNT_W | Saturating total of flagged bits |
| locked_o | output | 1 | Pattern lock with hysteresis |

## Verification
The bench uses DATA_W=8 and CNT_W=8. It drives an MSB-first instance and an LSB-first instance side by side with bit-reversed copies of the same words. With an 8-bit counter, saturation is reached within about a hundred random words. The bench sweeps all five patterns, one reserved select code and both inversion settings. In every run it covers the history fill, an idle gap, a single injected error, a random burst that drops lock and saturates the count, both clear cases, and relock after resynchronisation. Each result is compared against a bitwise model of the recurrence.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int MAXL  = 31;
  localparam int LEN_W = $clog2(MAXL + 1);

  typedef enum logic [2:0] {
    PAT_7  = 3'd0,
    PAT_9  = 3'd1,
    PAT_15 = 3'd2,
    PAT_23 = 3'd3,
    PAT_31 = 3'd4
  } pat_sel_e;

  // Length of the selected recurrence (highest power of the polynomial).
  function automatic logic [LEN_W-1:0] pat_len(input logic [2:0] sel);
    case (sel)
      PAT_7:   pat_len = LEN_W'(7);
      PAT_9:   pat_len = LEN_W'(9);
      PAT_15:  pat_len = LEN_W'(15);
      PAT_23:  pat_len = LEN_W'(23);
      default: pat_len = LEN_W'(31);
    endcase
  endfunction

  // Polynomial with the top power left out.
  function automatic logic [MAXL-1:0] pat_code(input logic [2:0] sel);
    case (sel)
      PAT_7:   pat_code = MAXL'(7'h41);
      PAT_9:   pat_code = MAXL'(9'h021);
      PAT_15:  pat_code = MAXL'(15'h4001);
      PAT_23:  pat_code = MAXL'(23'h040001);
      default: pat_code = MAXL'(31'h10000001);
    endcase
  endfunction

  // Stage mask: stage i holds the bit received i+1 bits ago.
  function automatic logic [MAXL-1:0] pat_taps(input logic [2:0] sel);
    logic [MAXL-1:0] code;
    int unsigned     len;
    code     = pat_code(sel);
    len      = int'(pat_len(sel));
    pat_taps = '0;
    for (int j = 1; j < MAXL; j++) begin
      if (j < len && code[j]) pat_taps[j-1] = 1'b1;
    end
    pat_taps[len-1] = 1'b1;
  endfunction

endpackage

// File: rtl/prbs_ff_unroll.sv
module prbs_ff_unroll #(
  parameter int DATA_W    = 8,
  parameter int MAXL      = 31,
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic [MAXL-1:0]   hist_i,
  input  logic [DATA_W-1:0] bits_i,
  input  logic [MAXL-1:0]   taps_i,
  output logic [MAXL-1:0]   hist_o,
  output logic [DATA_W-1:0] flag_o
);

  // One feed-forward stage per bit, chained in stream order.
  always_comb begin
    logic [MAXL-1:0] s;
    s      = hist_i;
    flag_o = '0;
    for (int k = 0; k < DATA_W; k++) begin
      int pos;
      pos         = LSB_FIRST ? k : (DATA_W - 1 - k);
      flag_o[pos] = bits_i[pos] ^ (^(s & taps_i));
      s           = {s[MAXL-2:0], bits_i[pos]};
    end
    hist_o = s;
  end

endmodule

// File: rtl/prbs_fill_gate.sv
module prbs_fill_gate #(
  parameter int DATA_W    = 8,
  parameter int MAXL      = 31,
  parameter bit LSB_FIRST = 1'b0,
  localparam int LEN_W    = $clog2(MAXL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] keep_o
);

  logic [LEN_W-1:0] fill_q;

  // A bit is trusted once a full recurrence length precedes it.
  always_comb begin
    keep_o = '0;
    for (int k = 0; k < DATA_W; k++) begin
      int pos;
      pos         = LSB_FIRST ? k : (DATA_W - 1 - k);
      keep_o[pos] = (int'(fill_q) + k) >= int'(len_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (adv_i) begin
      if (int'(fill_q) + DATA_W >= MAXL) fill_q <= LEN_W'(MAXL);
      else                               fill_q <= fill_q + LEN_W'(DATA_W);
    end
  end

endmodule

// File: rtl/prbs_err_accum.sv
module prbs_err_accum #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int PW    = $clog2(DATA_W + 1),
  localparam int SW    = CNT_W + PW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic [CNT_W-1:0]  count_o
);

  localparam logic [SW-1:0] LIMIT = SW'({CNT_W{1'b1}});

  logic [PW-1:0]    pop;
  logic [SW-1:0]    sum;
  logic [CNT_W-1:0] count_nx;

  always_comb begin
    pop = '0;
    for (int k = 0; k < DATA_W; k++) pop = pop + PW'(flags_i[k]);
    sum      = SW'(count_o) + SW'(pop);
    count_nx = (sum > LIMIT) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (adv_i)   count_o <= count_nx;
  end

endmodule

// File: rtl/prbs_lock_track.sv
module prbs_lock_track #(
  parameter int LOCK_GOOD  = 16,
  parameter int UNLOCK_BAD = 4,
  localparam int GW        = $clog2(LOCK_GOOD + 1),
  localparam int BW        = $clog2(UNLOCK_BAD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic dirty_i,
  output logic locked_o
);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q   <= '0;
      bad_q    <= '0;
      locked_o <= 1'b0;
    end else if (adv_i) begin
      if (dirty_i) begin
        good_q <= '0;
        if (bad_q != BW'(UNLOCK_BAD))     bad_q    <= bad_q + 1'b1;
        if (bad_q == BW'(UNLOCK_BAD - 1)) locked_o <= 1'b0;
      end else begin
        bad_q <= '0;
        if (good_q != GW'(LOCK_GOOD))     good_q   <= good_q + 1'b1;
        if (good_q == GW'(LOCK_GOOD - 1)) locked_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/prbs_par_checker.sv
module prbs_par_checker #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int LOCK_GOOD  = 16,
  parameter int UNLOCK_BAD = 4,
  parameter bit LSB_FIRST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        poly_sel_i,
  input  logic              invert_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] err_mask_o,
  output logic              err_valid_o,
  output logic [CNT_W-1:0]  err_count_o,
  output logic              locked_o
);
  import prbs_chk_pkg::*;

  logic [MAXL-1:0]   hist_q, hist_d, taps;
  logic [LEN_W-1:0]  len;
  logic [DATA_W-1:0] rx_bits, raw_flags, keep, flags;

  assign taps    = pat_taps(poly_sel_i);
  assign len     = pat_len(poly_sel_i);
  assign rx_bits = data_i ^ {DATA_W{invert_i}};
  assign flags   = raw_flags & keep;

  prbs_ff_unroll #(.DATA_W(DATA_W), .MAXL(MAXL), .LSB_FIRST(LSB_FIRST)) u_unroll (
    .hist_i (hist_q),
    .bits_i (rx_bits),
    .taps_i (taps),
    .hist_o (hist_d),
    .flag_o (raw_flags)
  );

  prbs_fill_gate #(.DATA_W(DATA_W), .MAXL(MAXL), .LSB_FIRST(LSB_FIRST)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (valid_i),
    .len_i  (len),
    .keep_o (keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q      <= '0;
      err_mask_o  <= '0;
      err_valid_o <= 1'b0;
    end else begin
      err_valid_o <= valid_i;
      err_mask_o  <= valid_i ? flags : '0;
      if (valid_i) hist_q <= hist_d;
    end
  end

  prbs_err_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (valid_i),
    .clear_i (clear_i),
    .flags_i (flags),
    .count_o (err_count_o)
  );

  prbs_lock_track #(.LOCK_GOOD(LOCK_GOOD), .UNLOCK_BAD(UNLOCK_BAD)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (valid_i),
    .dirty_i  (|flags),
    .locked_o (locked_o)
  );

endmodule

// File: rtl/prbs_par_checker_sva.sv
module prbs_par_checker_sva #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic              clear_i,
  input logic [DATA_W-1:0] err_mask_o,
  input logic              err_valid_o,
  input logic [CNT_W-1:0]  err_count_o,
  input logic              locked_o
);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (err_mask_o == '0 && !err_valid_o));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !clear_i) |=> ($stable(err_count_o) && $stable(locked_o)));

  assert_valid_echo_R6: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> err_valid_o);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !clear_i) |=>
      ((int'(err_count_o) == int'($past(err_count_o)) + $countones(err_mask_o)) ||
       (err_count_o == {CNT_W{1'b1}})));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (err_count_o == '0));

  assert_lock_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> (err_valid_o && err_mask_o == '0));

  assert_lock_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> (err_valid_o && err_mask_o != '0));

endmodule

bind prbs_par_checker prbs_par_checker_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .valid_i     (valid_i),
  .clear_i     (clear_i),
  .err_mask_o  (err_mask_o),
  .err_valid_o (err_valid_o),
  .err_count_o (err_count_o),
  .locked_o    (locked_o)
);

// File: tb/prbs_par_checker_tb_top.sv
module prbs_par_checker_tb_top;
  localparam int W    = 8;
  localparam int CW   = 8;
  localparam int CMAX = 255;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   sel = '0;
  logic         inv = 1'b0;
  logic [W-1:0] din = '0;
  logic         vld = 1'b0;
  logic         clr = 1'b0;
  logic [W-1:0] mask, mask_r;
  logic         ev, ev_r, lk, lk_r;
  logic [CW-1:0] cnt, cnt_r;

  function automatic logic [W-1:0] rev8(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) rev8[i] = v[W-1-i];
  endfunction

  logic [W-1:0] din_rev;
  assign din_rev = rev8(din);

  always #4 clk = ~clk;

  prbs_par_checker #(.DATA_W(W), .CNT_W(CW), .LSB_FIRST(1'b0)) dut_i (
    .clk(clk), .rst(rst), .poly_sel_i(sel), .invert_i(inv), .data_i(din),
    .valid_i(vld), .clear_i(clr), .err_mask_o(mask), .err_valid_o(ev),
    .err_count_o(cnt), .locked_o(lk));

  prbs_par_checker #(.DATA_W(W), .CNT_W(CW), .LSB_FIRST(1'b1)) dut_rev_i (
    .clk(clk), .rst(rst), .poly_sel_i(sel), .invert_i(inv), .data_i(din_rev),
    .valid_i(vld), .clear_i(clr), .err_mask_o(mask_r), .err_valid_o(ev_r),
    .err_count_o(cnt_r), .locked_o(lk_r));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state
  bit hist[2048];
  bit gen[2048];
  int nb, gn, plen, ptap, mcnt, gcnt, bcnt;
  bit mlk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (sel=%0d inv=%0d)",
               req, what, act, exp, sel, inv);
    end
  endtask

  task automatic set_poly(input int s);
    case (s)
      0: begin plen = 7;  ptap = 6;  end
      1: begin plen = 9;  ptap = 5;  end
      2: begin plen = 15; ptap = 14; end
      3: begin plen = 23; ptap = 18; end
      default: begin plen = 31; ptap = 28; end
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vld = 1'b0; clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    nb = 0; gn = 0; mcnt = 0; gcnt = 0; bcnt = 0; mlk = 1'b0;
    chk("R11", "mask after reset", int'(mask), 0);
    chk("R11", "count after reset", int'(cnt), 0);
    chk("R11", "lock after reset", int'(lk), 0);
    chk("R11", "valid echo after reset", int'(ev), 0);
  endtask

  task automatic gen_word(output logic [W-1:0] w);
    for (int k = W - 1; k >= 0; k--) begin
      bit g;
      if (gn < plen) g = 1'b1;
      else           g = gen[gn-plen] ^ gen[gn-ptap];
      gen[gn] = g;
      gn++;
      w[k] = g;
    end
  endtask

  task automatic send(input logic [W-1:0] w, input bit c, output logic [W-1:0] got);
    logic [W-1:0] em;
    int pc;
    em = '0;
    for (int k = W - 1; k >= 0; k--) begin
      bit b;
      b = w[k] ^ inv;
      hist[nb] = b;
      if (nb >= plen) em[k] = b ^ hist[nb-plen] ^ hist[nb-ptap];
      nb++;
    end
    pc = $countones(em);
    if (c) mcnt = 0;
    else   mcnt = (mcnt + pc > CMAX) ? CMAX : mcnt + pc;
    if (pc == 0) begin
      bcnt = 0;
      if (gcnt < 16) gcnt++;
      if (gcnt == 16) mlk = 1'b1;
    end else begin
      gcnt = 0;
      if (bcnt < 4) bcnt++;
      if (bcnt == 4) mlk = 1'b0;
    end
    @(negedge clk);
    din = w; vld = 1'b1; clr = c;
    @(posedge clk);
    #2;
    vld = 1'b0; clr = 1'b0;
    chk("R1", "error mask (R5 fill, R3 invert)", int'(mask), int'(em));
    chk("R6", "valid echo", int'(ev), 1);
    chk("R8", "error count (R9 on clear)", int'(cnt), mcnt);
    chk("R10", "lock flag", int'(lk), int'(mlk));
    chk("R2", "lsb-first mask", int'(mask_r), int'(rev8(em)));
    chk("R2", "lsb-first count", int'(cnt_r), mcnt);
    got = mask;
  endtask

  task automatic idle(input int n, input bit c);
    for (int i = 0; i < n; i++) begin
      int c0, l0;
      c0 = int'(cnt); l0 = int'(lk);
      @(negedge clk);
      din = W'($urandom); vld = 1'b0; clr = c;
      @(posedge clk);
      #2;
      clr = 1'b0;
      if (c) mcnt = 0;
      chk("R4", "idle valid echo", int'(ev), 0);
      chk("R4", "idle mask", int'(mask), 0);
      chk("R4", "idle count (R9 when clearing)", int'(cnt), c ? 0 : c0);
      chk("R4", "idle lock", int'(lk), l0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] g, got;
    int tot, c0;
    for (int s = 0; s <= 5; s++) begin
      for (int i = 0; i <= 1; i++) begin
        sel = 3'(s);
        inv = i[0];
        set_poly(s);
        do_reset();
        // Clean stream with an idle gap (R5, R4, R10)
        for (int w = 0; w < 24; w++) begin
          gen_word(g);
          send(g ^ {W{inv}}, 1'b0, got);
          if (w == 10) idle(3, 1'b0);
        end
        chk("R10", "locked after clean run", int'(lk), 1);
        chk("R3", "no errors on clean stream", int'(cnt), 0);
        // Single bit error (R7)
        c0 = mcnt;
        tot = 0;
        gen_word(g);
        send((g ^ {W{inv}}) ^ 8'h08, 1'b0, got);
        tot += $countones(got);
        for (int w = 0; w < 5; w++) begin
          gen_word(g);
          send(g ^ {W{inv}}, 1'b0, got);
          tot += $countones(got);
        end
        chk("R7", "flags from one flipped bit", tot, 3);
        chk("R7", "count after one flipped bit", int'(cnt), c0 + 3);
        chk("R10", "lock kept through single error", int'(lk), 1);
        // Random burst: saturation and unlock (R8, R10)
        for (int w = 0; w < 120; w++) send(W'($urandom), 1'b0, got);
        chk("R8", "saturated count", int'(cnt), CMAX);
        chk("R10", "unlocked after burst", int'(lk), 0);
        // Clear with a word, then clear while idle (R9)
        send(W'($urandom), 1'b1, got);
        send(8'hA5, 1'b0, got);
        send(8'h3C, 1'b0, got);
        idle(1, 1'b1);
        chk("R9", "count zero after idle clear", int'(cnt), 0);
        // Resynchronisation and relock (R1, R10)
        for (int w = 0; w < 24; w++) begin
          gen_word(g);
          send(g ^ {W{inv}}, 1'b0, got);
        end
        chk("R10", "relocked after resync", int'(lk), 1);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule